// File: doc/BRIEF.md
# Five-State Snooping Line Controller with Cache-to-Cache Supply

This block keeps the coherence state of every line in one private, direct-mapped cache on a snooped bus. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. The processor side issues reads and writes. The controller answers a hit at once. For a miss, and for a write to a line that other caches may hold, it raises a bus request and finishes the access in the cycle the bus grants it.

The snoop side watches every transaction that another cache places on the bus and answers in the same cycle. A cache holding the line raises its presence flag, which the bus ORs into the requester's shared input. The single holder that carries the freshest copy also raises a supply flag and a memory-abort flag, so the data comes from that cache and not from memory. A dirty line that is read by another cache moves to Owned. It is not written back, and from then on it is the only source for that line.

Two savings follow from this. A line filled with no other sharer becomes Exclusive, so a later write needs no bus transaction. A Modified line can be shared without a memory write. The bus arbiter, the data array and memory are outside this block. Several copies of the block sit around one bus, and the bus never snoops the cache that it has granted.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: the first access to any address raises a bus request, and no snooped address draws a presence, supply or abort response.
- R2: The bus command is 2'b01 for a read miss, 2'b10 for a write miss and 2'b11 for an invalidate. The bus address equals the processor address, and the command is never 2'b00 while a request is raised.
- R3: A read miss fills the line Exclusive when the shared input is low in the grant cycle, and Shared when it is high.
- R4: A write hit on an Exclusive or Modified line is acknowledged without a bus request and leaves the line Modified.
- R5: A write hit on a Shared or Owned line raises an invalidate, is acknowledged in the grant cycle and leaves the line Modified.
- R6: A write miss fills the line Modified.
- R7: On a snooped read miss, every valid holder raises the presence flag. A Modified holder moves to Owned, an Exclusive holder moves to Shared, and Modified, Owned and Exclusive holders raise supply and abort. Exclusive holders supply only when the clean-supply option is set.
- R8: A Shared holder never raises supply, so at most one cache supplies for any transaction.
- R9: An Owned line stays Owned and supplies on later snooped read misses. A snooped write miss makes Modified, Owned and Exclusive holders supply and then go Invalid, and Shared holders go Invalid. A snooped invalidate makes any holder Invalid with no supply.
- R10: A miss whose victim is Modified or Owned raises the write-back flag in the grant cycle with the victim's address. A clean victim raises no write-back.
- R11: A hit that needs no bus is not acknowledged in a cycle where a snoop is presented to this cache.
- R12: A request that needs the bus is acknowledged exactly in its grant cycle. Only one cache is granted at a time, and the granted cache is never snooped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_write | input | 1 | Access is a write |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_ack | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | Command of the wanted transaction |
| bus_addr | output | ADDR_W | Address of the wanted transaction |
| bus_grant | input | 1 | Bus granted to this cache this cycle |
| shared_in | input | 1 | OR of the other caches' presence flags |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the snooped line's data |
| snp_abort | output | 1 | Memory must drop its response |
| wb_valid | output | 1 | Dirty victim written back this cycle |
| wb_addr | output | ADDR_W | Address of the written-back victim |

## Verification
A wrong line state inside this block has no port of its own. It shows up at the next access that touches the line. A stale Exclusive or Modified state shows as a missing or extra bus request on the next write to that line. A wrong dirty state shows as a missing or extra supply flag on the next snoop, or as a missing or extra write-back when the line is evicted. So an error becomes visible as soon as the same cache or another cache touches the line again, usually within a few cycles. The bench checks every output of every cache in every cycle against a reference, so it catches each of these cases the first time it happens.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
   typedef enum logic [2:0] {
      LS_INV = 3'd0,
      LS_SHR = 3'd1,
      LS_EXC = 3'd2,
      LS_OWN = 3'd3,
      LS_MOD = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RDM  = 2'd1,
      BC_WRM  = 2'd2,
      BC_INV  = 2'd3
   } bus_cmd_e;
endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
   import moesi_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [TAG_W-1:0] ra_tag,
   output line_st_e         ra_st,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [TAG_W-1:0] rb_tag,
   output line_st_e         rb_st,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  line_st_e         wr_st
);
   localparam int LINES = 1 << IDX_W;

   line_st_e         st_q  [LINES];
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
      end else if (wr_en) begin
         st_q[wr_idx] <= wr_st;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_idx] <= wr_tag;
   end

   assign ra_tag = tag_q[ra_idx];
   assign ra_st  = st_q[ra_idx];
   assign rb_tag = tag_q[rb_idx];
   assign rb_st  = st_q[rb_idx];
endmodule

// File: rtl/moesi_cpu_side.sv
module moesi_cpu_side
   import moesi_pkg::*;
#(
   parameter int TAG_W = 5
) (
   input  logic             cpu_valid,
   input  logic             cpu_write,
   input  logic [TAG_W-1:0] cpu_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_st,
   input  logic             bus_grant,
   input  logic             shared_in,
   input  logic             snp_valid,
   output logic             bus_req,
   output bus_cmd_e         bus_cmd,
   output logic             cpu_ack,
   output logic             wb_valid,
   output logic             upd_en,
   output line_st_e         upd_st
);
   logic hit, need_bus, dirty, upgrade;

   always_comb begin
      hit      = (line_st != LS_INV) && (line_tag == cpu_tag);
      upgrade  = hit && cpu_write && (line_st == LS_SHR || line_st == LS_OWN);
      need_bus = !hit || upgrade;
      dirty    = (line_st == LS_MOD) || (line_st == LS_OWN);

      bus_req  = cpu_valid && need_bus;
      if (!bus_req)       bus_cmd = BC_NONE;
      else if (hit)       bus_cmd = BC_INV;
      else if (cpu_write) bus_cmd = BC_WRM;
      else                bus_cmd = BC_RDM;

      cpu_ack  = cpu_valid && (need_bus ? bus_grant : !snp_valid);
      wb_valid = cpu_ack && !hit && dirty;

      upd_en = 1'b0;
      upd_st = line_st;
      if (cpu_ack) begin
         if (!hit) begin
            upd_en = 1'b1;
            upd_st = cpu_write ? LS_MOD : (shared_in ? LS_SHR : LS_EXC);
         end else if (cpu_write && line_st != LS_MOD) begin
            upd_en = 1'b1;
            upd_st = LS_MOD;
         end
      end
   end
endmodule

// File: rtl/moesi_snoop_side.sv
module moesi_snoop_side
   import moesi_pkg::*;
#(
   parameter int TAG_W        = 5,
   parameter bit SUPPLY_CLEAN = 1'b1
) (
   input  logic             snp_valid,
   input  bus_cmd_e         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_st,
   output logic             present,
   output logic             supply,
   output logic             upd_en,
   output line_st_e         upd_st
);
   logic can_supply;

   generate
      if (SUPPLY_CLEAN) begin : g_clean_src
         assign can_supply = (line_st == LS_MOD) || (line_st == LS_OWN) || (line_st == LS_EXC);
      end else begin : g_dirty_src
         assign can_supply = (line_st == LS_MOD) || (line_st == LS_OWN);
      end
   endgenerate

   always_comb begin
      present = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
      supply  = present && (snp_cmd == BC_RDM || snp_cmd == BC_WRM) && can_supply;
      upd_st  = line_st;
      case (snp_cmd)
         BC_RDM: begin
            if (line_st == LS_MOD)      upd_st = LS_OWN;
            else if (line_st == LS_EXC) upd_st = LS_SHR;
         end
         BC_WRM, BC_INV: upd_st = LS_INV;
         default: upd_st = line_st;
      endcase
      upd_en = present && (upd_st != line_st);
   end
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
   import moesi_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int IDX_W        = 3,
   parameter bit SUPPLY_CLEAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_ack,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_grant,
   input  logic              shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_supply,
   output logic              snp_abort,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr
);
   localparam int TAG_W = ADDR_W - IDX_W;

   generate
      if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
         $error("moesi_snoop_ctrl: IDX_W must be in 1..ADDR_W-1");
      end
   endgenerate

   logic [IDX_W-1:0] c_idx, s_idx;
   logic [TAG_W-1:0] c_tag, s_tag, c_line_tag, s_line_tag;
   line_st_e         c_line_st, s_line_st, c_upd_st, s_upd_st, wr_st;
   logic             c_upd_en, s_upd_en, wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;
   bus_cmd_e         c_cmd;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   moesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (c_idx),
      .ra_tag (c_line_tag),
      .ra_st  (c_line_st),
      .rb_idx (s_idx),
      .rb_tag (s_line_tag),
      .rb_st  (s_line_st),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_tag (wr_tag),
      .wr_st  (wr_st)
   );

   moesi_cpu_side #(.TAG_W(TAG_W)) u_cpu (
      .cpu_valid (cpu_valid),
      .cpu_write (cpu_write),
      .cpu_tag   (c_tag),
      .line_tag  (c_line_tag),
      .line_st   (c_line_st),
      .bus_grant (bus_grant),
      .shared_in (shared_in),
      .snp_valid (snp_valid),
      .bus_req   (bus_req),
      .bus_cmd   (c_cmd),
      .cpu_ack   (cpu_ack),
      .wb_valid  (wb_valid),
      .upd_en    (c_upd_en),
      .upd_st    (c_upd_st)
   );

   moesi_snoop_side #(.TAG_W(TAG_W), .SUPPLY_CLEAN(SUPPLY_CLEAN)) u_snp (
      .snp_valid (snp_valid),
      .snp_cmd   (bus_cmd_e'(snp_cmd)),
      .snp_tag   (s_tag),
      .line_tag  (s_line_tag),
      .line_st   (s_line_st),
      .present   (snp_shared),
      .supply    (snp_supply),
      .upd_en    (s_upd_en),
      .upd_st    (s_upd_st)
   );

   // A snooped change and a local change never meet in one cycle: the
   // granted cache is not snooped and bus-free hits stall during snoops.
   always_comb begin
      wr_en  = s_upd_en || c_upd_en;
      wr_idx = s_upd_en ? s_idx      : c_idx;
      wr_tag = s_upd_en ? s_line_tag : c_tag;
      wr_st  = s_upd_en ? s_upd_st   : c_upd_st;
   end

   assign bus_cmd   = c_cmd;
   assign bus_addr  = cpu_addr;
   assign snp_abort = snp_supply;
   assign wb_addr   = {c_line_tag, c_idx};
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_write,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ack,
   input logic              bus_req,
   input logic [1:0]        bus_cmd,
   input logic              bus_grant,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic              snp_shared,
   input logic              snp_supply,
   input logic              wb_valid
);
   a_r7_supply_implies_present: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> snp_shared);

   a_r9_no_supply_on_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_valid && snp_cmd != 2'd3));

   a_r10_writeback_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (bus_grant && bus_req && bus_cmd != 2'd3));

   a_r2_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd != 2'd0));

   a_r11_free_hit_not_snooped: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !bus_req) |-> !snp_valid);

   a_r12_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> (bus_req && cpu_ack && !snp_valid));

   a_r4_rewrite_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_write) |=>
         !(cpu_valid && cpu_write && cpu_addr == $past(cpu_addr) && bus_req));
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/moesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_tb;
   localparam int AW = 8;
   localparam int IW = 3;
   localparam int NC = 3;
   // model state codes
   localparam int I_ = 0, S_ = 1, E_ = 2, O_ = 3, M_ = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NC-1:0] cv, cw, ack, breq, grant, shin, sv, sh, sup, ab, wbv;
   logic [AW-1:0] ca [NC];
   logic [AW-1:0] baddr [NC];
   logic [AW-1:0] wba [NC];
   logic [1:0]    bcmd [NC];
   logic [1:0]    scmd;
   logic [AW-1:0] saddr;

   for (genvar g = 0; g < NC; g++) begin : g_cache
      moesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .SUPPLY_CLEAN(1'b1)) u_dut (
         .clk(clk), .rst_n(rst_n),
         .cpu_valid(cv[g]), .cpu_write(cw[g]), .cpu_addr(ca[g]), .cpu_ack(ack[g]),
         .bus_req(breq[g]), .bus_cmd(bcmd[g]), .bus_addr(baddr[g]),
         .bus_grant(grant[g]), .shared_in(shin[g]),
         .snp_valid(sv[g]), .snp_cmd(scmd), .snp_addr(saddr),
         .snp_shared(sh[g]), .snp_supply(sup[g]), .snp_abort(ab[g]),
         .wb_valid(wbv[g]), .wb_addr(wba[g]));
   end

   // simple bus: lowest requester wins, others snoop it
   always_comb begin
      automatic int gi = -1;
      for (int i = 0; i < NC; i++) if (breq[i] && gi < 0) gi = i;
      grant = '0; sv = '0; shin = '0; scmd = 2'd0; saddr = '0;
      if (gi >= 0) begin
         grant[gi] = 1'b1;
         scmd  = bcmd[gi];
         saddr = baddr[gi];
         for (int j = 0; j < NC; j++) if (j != gi) sv[j] = 1'b1;
         shin[gi] = |(sh & ~(NC'(1) << gi));
      end
   end

   int nchk = 0, nerr = 0;
   int ms [NC][8];
   int mt [NC][8];

   task automatic chk(input string tag, input string what, input int c,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s cache%0d %s: actual %0h expected %0h", tag, c, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic [2:0] v, input logic [2:0] w,
                       input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
      int eg, nsup;
      int hit [NC];
      int need [NC];
      logic [1:0] ec [NC];
      logic eshin;
      logic [NC-1:0] esh;
      @(negedge clk);
      cv = v; cw = w; ca[0] = a0; ca[1] = a1; ca[2] = a2;
      #1;
      eg = -1;
      for (int c = 0; c < NC; c++) begin
         int ix = ca[c] % 8, tg = ca[c] / 8;
         hit[c]  = (ms[c][ix] != I_ && mt[c][ix] == tg) ? 1 : 0;
         need[c] = (hit[c] == 0 || (cw[c] && (ms[c][ix] == S_ || ms[c][ix] == O_))) ? 1 : 0;
         ec[c]   = (hit[c] == 1) ? 2'd3 : (cw[c] ? 2'd2 : 2'd1);
         if (cv[c] && need[c] == 1 && eg < 0) eg = c;
      end
      esh = '0; nsup = 0;
      for (int c = 0; c < NC; c++) begin
         logic e_ack, e_sh, e_sup, e_wb;
         int ix = ca[c] % 8;
         e_sh = 1'b0; e_sup = 1'b0; e_wb = 1'b0;
         chk(tag, "bus_req", c, breq[c], cv[c] && need[c] == 1);
         if (cv[c] && need[c] == 1) begin
            chk(tag, "bus_cmd", c, bcmd[c], ec[c]);
            chk(tag, "bus_addr", c, baddr[c], ca[c]);
         end
         if (c == eg) begin
            e_ack = 1'b1;
            e_wb  = (hit[c] == 0) && (ms[c][ix] == M_ || ms[c][ix] == O_);
         end else begin
            e_ack = cv[c] && need[c] == 0 && eg < 0;
            if (eg >= 0) begin
               int sx = ca[eg] % 8, st = ca[eg] / 8, s = ms[c][ca[eg] % 8];
               e_sh  = (s != I_ && mt[c][sx] == st);
               e_sup = e_sh && ec[eg] != 2'd3 && (s == M_ || s == O_ || s == E_);
            end
         end
         esh[c] = e_sh;
         if (sup[c]) nsup++;
         chk(tag, "cpu_ack", c, ack[c], e_ack);
         chk(tag, "wb_valid", c, wbv[c], e_wb);
         if (e_wb) chk(tag, "wb_addr", c, wba[c], {mt[c][ix][4:0], ix[2:0]});
         chk(tag, "snp_shared", c, sh[c], e_sh);
         chk(tag, "snp_supply", c, sup[c], e_sup);
         chk(tag, "snp_abort", c, ab[c], e_sup);
      end
      chk({tag, "/R8"}, "supplier count<=1", 0, nsup <= 1, 1);
      eshin = |esh;
      // advance the model
      for (int c = 0; c < NC; c++) begin
         int ix = ca[c] % 8;
         if (c == eg) begin
            if (hit[c] == 0) begin
               mt[c][ix] = ca[c] / 8;
               ms[c][ix] = cw[c] ? M_ : (eshin ? S_ : E_);
            end else ms[c][ix] = M_;
         end else if (eg >= 0) begin
            int sx = ca[eg] % 8;
            if (esh[c]) begin
               if (ec[eg] == 2'd1) begin
                  if (ms[c][sx] == M_) ms[c][sx] = O_;
                  else if (ms[c][sx] == E_) ms[c][sx] = S_;
               end else ms[c][sx] = I_;
            end
         end else if (cv[c] && need[c] == 0 && cw[c]) ms[c][ix] = M_;
      end
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      cv = '0; cw = '0;
      for (int c = 0; c < NC; c++) begin
         ca[c] = '0;
         for (int i = 0; i < 8; i++) begin ms[c][i] = I_; mt[c][i] = 0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      step("R1 idle",            3'b000, 3'b000, 8'h00, 8'h00, 8'h00);
      step("R1 R2 R3 fill E",    3'b001, 3'b000, 8'h10, 8'h00, 8'h00);
      step("R4 silent E write",  3'b001, 3'b001, 8'h10, 8'h00, 8'h00);
      step("R4 silent M write",  3'b001, 3'b001, 8'h10, 8'h00, 8'h00);
      step("R7 M to O supply",   3'b010, 3'b000, 8'h00, 8'h10, 8'h00);
      step("R9 R8 O supplies",   3'b100, 3'b000, 8'h00, 8'h00, 8'h10);
      step("R5 S upgrade inv",   3'b010, 3'b010, 8'h00, 8'h10, 8'h00);
      step("R7 second owner",    3'b001, 3'b000, 8'h10, 8'h00, 8'h00);
      step("R5 O upgrade inv",   3'b010, 3'b010, 8'h00, 8'h10, 8'h00);
      step("R7 owner again",     3'b001, 3'b000, 8'h10, 8'h00, 8'h00);
      step("R6 R9 write miss",   3'b100, 3'b100, 8'h00, 8'h00, 8'h10);
      step("R10 M victim wb",    3'b100, 3'b000, 8'h00, 8'h00, 8'h18);
      step("R12 two requests",   3'b011, 3'b000, 8'h20, 8'h21, 8'h00);
      step("R12 loser granted",  3'b010, 3'b000, 8'h00, 8'h21, 8'h00);
      step("R11 hit stalled",    3'b101, 3'b000, 8'h33, 8'h00, 8'h18);
      step("R11 hit completes",  3'b100, 3'b000, 8'h00, 8'h00, 8'h18);
      step("R7 E supplies",      3'b001, 3'b000, 8'h18, 8'h00, 8'h00);
      step("R10 E victim no wb", 3'b010, 3'b000, 8'h00, 8'h29, 8'h00);
      step("R6 R8 S no supply",  3'b010, 3'b010, 8'h00, 8'h18, 8'h00);
      step("R7 to owned",        3'b001, 3'b000, 8'h18, 8'h00, 8'h00);
      step("R10 O victim wb",    3'b010, 3'b000, 8'h00, 8'h58, 8'h00);
      step("R3 fill S",          3'b100, 3'b000, 8'h00, 8'h00, 8'h18);
      step("R5 S upgrade",       3'b100, 3'b100, 8'h00, 8'h00, 8'h18);
      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         logic [2:0] rv, rw;
         logic [7:0] ra [NC];
         for (int c = 0; c < NC; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rv[c] = lf[0] | lf[1];
            rw[c] = lf[2];
            ra[c] = {3'b000, lf[4:3], 1'b0, lf[6:5]};
         end
         step("R9 random", rv, rw, ra[0], ra[1], ra[2]);
      end
      step("R1 idle end", 3'b000, 3'b000, 8'h00, 8'h00, 8'h00);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule